// File: doc/BRIEF.md
# TDM Codec Serial Control Port

This block is the digital front of a voice codec on a 2.048 MHz bit clock with a 125 µs frame. An active-low frame strobe opens one eight-bit timeslot. During that slot the port shifts in one PCM byte and one control byte, and it shifts one PCM byte out. Serial input is sampled on the falling clock edge. Serial output changes on the rising edge and has its own output-enable, so that the line can be shared with other timeslots.

A two-bit code stands for the three-level control-address pin. This code steers the control byte into one of two registers. It also decides whether the second register is cleared, and whether PCM transfer is suppressed for that slot. A frame may carry two strobes: one slot loads the first register and a second slot loads the second register. A strap pin selects static control instead. In that mode the serial control pin acts as a plain level that selects power-down. The top two bits of register A select normal operation, digital loopback, analog loopback or power-down. After reset, both registers stay at the power-down setting for a programmable number of clocks and ignore writes during that time.

Top module: `tdm_ctl_port`

## Requirements
- R1: For HOLD_CYC clocks after reset release, reg_a_o reads 8'hC0, reg_b_o reads 0 and pwrdn_o is high. A control byte completed inside that window changes neither register.
- R2: pcm_tx_oe_o is low whenever frame_ni is high. In an enabled slot it is high for exactly the 8 falling edges of the slot. The byte goes out MSB first: bit 7 appears when the strobe falls, and each rising edge inside the slot presents the next bit.
- R3: pcm_rx_i and ctl_i are sampled on falling edges, MSB first. At the rising edge that follows the 8th falling edge of a slot, rx_word_o takes the PCM byte and rx_valid_o goes high for exactly one clock.
- R4: If the strobe rises before 8 bits have been taken, the partial byte is discarded: rx_valid_o does not pulse and neither register changes.
- R5: Control-address code 2'b00 (negative level), serial mode: the control byte loads register A and register B is cleared to zero.
- R6: Code 2'b01 (ground level): the control byte loads register A and register B keeps its value.
- R7: Code 2'b10 (positive level): the control byte loads register B and register A keeps its value. In that slot pcm_tx_oe_o stays low and rx_valid_o does not pulse.
- R8: Code 2'b11 is reserved. The control byte is dropped and PCM transfer runs normally.
- R9: reg_a_o[7:6] selects the mode: 00 normal, 01 digital loopback (dloop_o), 10 analog loopback (aloop_o), 11 power-down (pwrdn_o). While pwrdn_o is high, pcm_tx_oe_o stays low.
- R10: In digital loopback the transmitted byte is the most recent received PCM byte, and rx_word_o reports zero.
- R11: With static_i high, pwrdn_o follows the level of ctl_i as sampled on the previous falling edge, no slot writes either register, the control-address code is ignored, and the loop flags are low.
- R12: Two strobes in one frame, one with code 2'b01 and one with 2'b10, load register A and then register B, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2.048 MHz bit clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| frame_ni | input | 1 | Active-low timeslot strobe |
| ca_i | input | 2 | Control-address code: 00 negative, 01 ground, 10 positive, 11 reserved |
| static_i | input | 1 | Strap: 1 selects static control |
| pcm_rx_i | input | 1 | Serial PCM input |
| ctl_i | input | 1 | Serial control input, or power-down level in static mode |
| tx_word_i | input | WORD_W | Byte from the encoder, to be transmitted |
| pcm_tx_o | output | 1 | Serial PCM output data |
| pcm_tx_oe_o | output | 1 | Output enable for pcm_tx_o |
| rx_word_o | output | WORD_W | Last received PCM byte, toward the decoder |
| rx_valid_o | output | 1 | One-clock pulse when a PCM byte completes |
| reg_a_o | output | WORD_W | Control register A |
| reg_b_o | output | WORD_W | Control register B |
| pwrdn_o | output | 1 | Power-down in force |
| dloop_o | output | 1 | Digital loopback selected |
| aloop_o | output | 1 | Analog loopback selected |

## Verification
The bench keeps WORD_W at 8 and lowers HOLD_CYC to 20. With that setting a complete control slot can finish inside the power-up window right after reset, and the exit from the window is reached a few clocks later. The byte width of 8 keeps the mode field at bits 7:6, so random control bytes land on all four modes, including loopback and power-down. The random slots, seeded and mixed over all four address codes with occasional truncated strobes, exercise both register-steering rules and byte discard.

// File: rtl/tdmcp_pkg.sv
package tdmcp_pkg;

   typedef enum logic [1:0] {
      CA_NEG = 2'b00,
      CA_GND = 2'b01,
      CA_POS = 2'b10,
      CA_RSV = 2'b11
   } ca_code_e;

   typedef enum logic [1:0] {
      MD_NORMAL = 2'b00,
      MD_DLOOP  = 2'b01,
      MD_ALOOP  = 2'b10,
      MD_PDOWN  = 2'b11
   } path_mode_e;

   // Sampled pin bundle, frame strobe on top.
   typedef struct packed {
      logic     frame_n;
      logic     pcm;
      logic     ctl;
      ca_code_e ca;
   } pins_t;

   localparam int PINS_W = $bits(pins_t);

endpackage

// File: rtl/tdmcp_sampler.sv
module tdmcp_sampler #(
   parameter int          W       = 5,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("tdmcp_sampler: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o[i] <= RST_VAL[i];
         else         q_o[i] <= d_i[i];
      end
   end

endmodule

// File: rtl/tdmcp_slot.sv
module tdmcp_slot
   import tdmcp_pkg::*;
#(
   parameter int WORD_W = 8,
   localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_n_i,
   input  logic              pcm_i,
   input  logic              ctl_i,
   input  ca_code_e          ca_i,
   output logic              shift_o,
   output logic              done_o,
   output logic              commit_o,
   output logic [WORD_W-1:0] pcm_word_o,
   output logic [WORD_W-1:0] ctl_word_o,
   output ca_code_e          ca_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   if (WORD_W < 2) begin : g_bad_w
      $error("tdmcp_slot: WORD_W must be at least 2");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic [WORD_W-1:0] pcm_sr_q, ctl_sr_q;
   ca_code_e          ca_q;

   assign shift_o    = !frame_n_i && !done_q;
   assign commit_o   = shift_o && (cnt_q == LAST);
   assign pcm_word_o = {pcm_sr_q[WORD_W-2:0], pcm_i};
   assign ctl_word_o = {ctl_sr_q[WORD_W-2:0], ctl_i};
   assign done_o     = done_q;
   assign ca_o       = ca_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         done_q   <= 1'b0;
         pcm_sr_q <= '0;
         ctl_sr_q <= '0;
         ca_q     <= CA_NEG;
      end else if (frame_n_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         pcm_sr_q <= pcm_word_o;
         ctl_sr_q <= ctl_word_o;
         if (cnt_q == '0) ca_q <= ca_i;
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o |=> !commit_o); // R3
   AST_GAP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_n_i |=> (cnt_q == '0 && !done_q)); // R4

endmodule

// File: rtl/tdmcp_ctlregs.sv
module tdmcp_ctlregs
   import tdmcp_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int HOLD_CYC = 25
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] ctl_word_i,
   input  ca_code_e          ca_i,
   input  logic              static_i,
   input  logic              ctl_lvl_i,
   output logic [WORD_W-1:0] reg_a_o,
   output logic [WORD_W-1:0] reg_b_o,
   output logic              pwrdn_o,
   output logic              dloop_o,
   output logic              aloop_o
);

   localparam logic [WORD_W-1:0] A_RST = {2'b11, {(WORD_W-2){1'b0}}};

   if (WORD_W < 2) begin : g_bad_w
      $error("tdmcp_ctlregs: WORD_W must be at least 2");
   end
   if (HOLD_CYC < 0) begin : g_bad_hold
      $error("tdmcp_ctlregs: HOLD_CYC must not be negative");
   end

   logic hold;

   if (HOLD_CYC > 0) begin : g_hold
      localparam int HOLD_W = $clog2(HOLD_CYC + 1);
      localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_CYC);
      logic [HOLD_W-1:0] hcnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)              hcnt_q <= '0;
         else if (hcnt_q != HOLD_END) hcnt_q <= hcnt_q + 1'b1;
      end
      assign hold = (hcnt_q != HOLD_END);
   end else begin : g_nohold
      assign hold = 1'b0;
   end

   logic [WORD_W-1:0] reg_a_q, reg_b_q;
   logic              static_pd_q;
   logic              wr_ok;
   path_mode_e        mode;

   assign wr_ok = commit_i && !hold && !static_i;
   assign mode  = path_mode_e'(reg_a_q[WORD_W-1 -: 2]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reg_a_q     <= A_RST;
         reg_b_q     <= '0;
         static_pd_q <= 1'b1;
      end else begin
         static_pd_q <= ctl_lvl_i;
         if (wr_ok) begin
            unique case (ca_i)
               CA_NEG: begin
                  reg_a_q <= ctl_word_i;
                  reg_b_q <= '0;
               end
               CA_GND: reg_a_q <= ctl_word_i;
               CA_POS: reg_b_q <= ctl_word_i;
               default: ;
            endcase
         end
      end
   end

   assign reg_a_o = reg_a_q;
   assign reg_b_o = reg_b_q;
   assign pwrdn_o = hold || (static_i ? static_pd_q : (mode == MD_PDOWN));
   assign dloop_o = !hold && !static_i && (mode == MD_DLOOP);
   assign aloop_o = !hold && !static_i && (mode == MD_ALOOP);

   AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold |=> ($stable(reg_a_q) && $stable(reg_b_q))); // R1
   AST_NEG_CLEARS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && ca_i == CA_NEG) |=> (reg_b_q == '0)); // R5
   AST_GND_KEEPS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && ca_i == CA_GND) |=> $stable(reg_b_q)); // R6
   AST_POS_KEEPS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && ca_i == CA_POS) |=> $stable(reg_a_q)); // R7
   AST_RSV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && ca_i == CA_RSV) |=> ($stable(reg_a_q) && $stable(reg_b_q))); // R8
   AST_STATIC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      static_i |=> ($stable(reg_a_q) && $stable(reg_b_q))); // R11

endmodule

// File: rtl/tdmcp_txser.sv
module tdmcp_txser #(
   parameter int WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              slot_open_i,
   input  logic              enable_i,
   output logic              bit_o,
   output logic              oe_o
);

   if (WORD_W < 2) begin : g_bad_w
      $error("tdmcp_txser: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sr_q <= '0;
      else if (load_i)   sr_q <= word_i;
      else if (shift_i)  sr_q <= {sr_q[WORD_W-2:0], 1'b0};
   end

   assign bit_o = sr_q[WORD_W-1];
   assign oe_o  = slot_open_i && enable_i;

endmodule

// File: rtl/tdm_ctl_port.sv
module tdm_ctl_port
   import tdmcp_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int HOLD_CYC = 25
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_ni,
   input  logic [1:0]        ca_i,
   input  logic              static_i,
   input  logic              pcm_rx_i,
   input  logic              ctl_i,
   input  logic [WORD_W-1:0] tx_word_i,
   output logic              pcm_tx_o,
   output logic              pcm_tx_oe_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_valid_o,
   output logic [WORD_W-1:0] reg_a_o,
   output logic [WORD_W-1:0] reg_b_o,
   output logic              pwrdn_o,
   output logic              dloop_o,
   output logic              aloop_o
);

   localparam pins_t PINS_RST = '{frame_n: 1'b1, pcm: 1'b0, ctl: 1'b0, ca: CA_NEG};

   if (WORD_W < 2) begin : g_bad_w
      $error("tdm_ctl_port: WORD_W must be at least 2");
   end

   pins_t pins_raw, pins_s;
   assign pins_raw = '{frame_n: frame_ni, pcm: pcm_rx_i, ctl: ctl_i, ca: ca_code_e'(ca_i)};

   tdmcp_sampler #(.W(PINS_W), .RST_VAL(PINS_RST)) u_smp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   logic              shift, done, commit;
   logic [WORD_W-1:0] pcm_word, ctl_word;
   ca_code_e          slot_ca;

   tdmcp_slot #(.WORD_W(WORD_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .frame_n_i (pins_s.frame_n),
      .pcm_i     (pins_s.pcm),
      .ctl_i     (pins_s.ctl),
      .ca_i      (pins_s.ca),
      .shift_o   (shift),
      .done_o    (done),
      .commit_o  (commit),
      .pcm_word_o(pcm_word),
      .ctl_word_o(ctl_word),
      .ca_o      (slot_ca)
   );

   tdmcp_ctlregs #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .ctl_word_i(ctl_word),
      .ca_i      (slot_ca),
      .static_i  (static_i),
      .ctl_lvl_i (pins_s.ctl),
      .reg_a_o   (reg_a_o),
      .reg_b_o   (reg_b_o),
      .pwrdn_o   (pwrdn_o),
      .dloop_o   (dloop_o),
      .aloop_o   (aloop_o)
   );

   // PCM path: slot code POS suppresses transfer unless the strap is set.
   logic              pcm_ok, tx_enable;
   logic [WORD_W-1:0] last_rx_q, rx_word_q, tx_src;
   logic              rx_valid_q;

   assign pcm_ok    = static_i || (slot_ca != CA_POS);
   assign tx_enable = !pwrdn_o && (static_i || (ca_code_e'(ca_i) != CA_POS));
   assign tx_src    = dloop_o ? last_rx_q : tx_word_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_valid_q <= 1'b0;
         rx_word_q  <= '0;
         last_rx_q  <= '0;
      end else begin
         rx_valid_q <= commit && pcm_ok;
         if (commit && pcm_ok) begin
            rx_word_q <= dloop_o ? '0 : pcm_word;
            last_rx_q <= pcm_word;
         end
      end
   end

   tdmcp_txser #(.WORD_W(WORD_W)) u_tx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (pins_s.frame_n),
      .shift_i    (shift),
      .word_i     (tx_src),
      .slot_open_i(!frame_ni && !done),
      .enable_i   (tx_enable),
      .bit_o      (pcm_tx_o),
      .oe_o       (pcm_tx_oe_o)
   );

   assign rx_word_o  = rx_word_q;
   assign rx_valid_o = rx_valid_q;

   AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_q |=> !rx_valid_q); // R3
   AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ni |-> !pcm_tx_oe_o); // R2
   AST_PDOWN_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwrdn_o |-> !pcm_tx_oe_o); // R9
   AST_DLOOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && pcm_ok && dloop_o) |=> (rx_word_q == '0)); // R10

endmodule

// File: tb/tdm_ctl_port_test.sv
`timescale 1ns/1ps
module tdm_ctl_port_test;

   localparam int CLK_PERIOD = 488;
   localparam int WORD_W     = 8;
   localparam int HOLD_CYC   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1;
   logic [1:0] ca = 2'b00;
   logic static_s = 1'b0;
   logic pcm_in = 1'b0;
   logic ctl_in = 1'b0;
   logic [7:0] tx_word = '0;
   logic pcm_tx, pcm_oe, rx_valid, pwrdn, dloop, aloop;
   logic [7:0] rx_word, reg_a, reg_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_ctl_port #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) uut (
      .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .ca_i(ca),
      .static_i(static_s), .pcm_rx_i(pcm_in), .ctl_i(ctl_in),
      .tx_word_i(tx_word), .pcm_tx_o(pcm_tx), .pcm_tx_oe_o(pcm_oe),
      .rx_word_o(rx_word), .rx_valid_o(rx_valid), .reg_a_o(reg_a),
      .reg_b_o(reg_b), .pwrdn_o(pwrdn), .dloop_o(dloop), .aloop_o(aloop)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Bench model state
   logic [7:0] m_a = 8'hC0;
   logic [7:0] m_b = 8'h00;
   logic [7:0] m_last = 8'h00;
   logic       m_hold = 1'b1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string ca_req(input logic [1:0] c);
      case (c)
         2'b00:   return "R5";
         2'b01:   return "R6";
         2'b10:   return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [7:0] nxt_a(input logic [1:0] c, input logic [7:0] a, input logic [7:0] w);
      return (c == 2'b00 || c == 2'b01) ? w : a;
   endfunction

   function automatic logic [7:0] nxt_b(input logic [1:0] c, input logic [7:0] b, input logic [7:0] w);
      case (c)
         2'b00:   return 8'h00;
         2'b10:   return w;
         default: return b;
      endcase
   endfunction

   // One timeslot with full checking against the bench model.
   task automatic slot(input logic [1:0] c, input logic [7:0] pcm, input logic [7:0] ctl,
                       input logic [7:0] txw, input int nbits);
      logic [7:0] cap;
      int         oe_cnt;
      logic       v_now, v_after, pd, dl, inh, wr;
      logic [7:0] rx_now;
      string      rq;
      pd  = m_hold || (static_s ? 1'b0 : (m_a[7:6] == 2'b11));
      dl  = !m_hold && !static_s && (m_a[7:6] == 2'b01);
      inh = !static_s && (c == 2'b10);
      wr  = (nbits == 8) && !m_hold && !static_s;
      ca = c; tx_word = txw; frame_n = 1'b1;
      @(posedge clk); #1;
      frame_n = 1'b0; pcm_in = pcm[7]; ctl_in = ctl[7]; cap = '0; oe_cnt = 0;
      for (int k = 0; k < nbits; k++) begin
         @(negedge clk);
         if (pcm_oe) oe_cnt++;
         cap[7-k] = pcm_tx;
         @(posedge clk); #1;
         if (k < 7) begin pcm_in = pcm[6-k]; ctl_in = ctl[6-k]; end
      end
      v_now = rx_valid; rx_now = rx_word;
      frame_n = 1'b1;
      @(posedge clk); #1;
      v_after = rx_valid;
      @(posedge clk); #1;
      rq = pd ? "R9" : (inh ? "R7" : "R2");
      chk(rq, "oe_count", oe_cnt, (pd || inh) ? nbits - nbits : nbits);
      if (!pd && !inh && nbits == 8)
         chk(dl ? "R10" : "R2", "tx_byte", cap, dl ? m_last : txw);
      rq = (nbits < 8) ? "R4" : (inh ? "R7" : "R3");
      chk(rq, "rx_valid", v_now, (nbits == 8) && !inh);
      chk("R3", "rx_valid_width", v_after, 1'b0);
      if (nbits == 8 && !inh) begin
         chk(dl ? "R10" : "R3", "rx_word", rx_now, dl ? 8'h00 : pcm);
         m_last = pcm;
      end
      if (wr) begin
         m_a = nxt_a(c, m_a, ctl);
         m_b = nxt_b(c, m_b, ctl);
      end
      rq = m_hold ? "R1" : (static_s ? "R11" : ((nbits < 8) ? "R4" : ca_req(c)));
      chk(rq, "reg_a", reg_a, m_a);
      chk(rq, "reg_b", reg_b, m_b);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "reset reg_a", reg_a, 8'hC0);
      chk("R1", "reset reg_b", reg_b, 8'h00);
      chk("R1", "reset pwrdn", pwrdn, 1'b1);
      chk("R2", "reset oe", pcm_oe, 1'b0);
      chk("R3", "reset rx_valid", rx_valid, 1'b0);
      rst_n = 1'b1;
      // R1: write inside the hold window is dropped
      slot(2'b00, 8'h5A, 8'h05, 8'h81, 8);
      chk("R1", "pwrdn in hold", pwrdn, 1'b1);
      repeat (HOLD_CYC + 4) @(posedge clk);
      #1;
      m_hold = 1'b0;
      chk("R9", "pwrdn after hold (mode 11)", pwrdn, 1'b1);
      // R5 then R12: two strobes in one frame
      slot(2'b00, 8'hA5, 8'h00, 8'h3C, 8);
      chk("R9", "pwrdn normal", pwrdn, 1'b0);
      slot(2'b01, 8'h96, 8'h07, 8'hE1, 8);
      slot(2'b10, 8'h44, 8'h5A, 8'h12, 8);
      chk("R12", "A from first strobe", reg_a, 8'h07);
      chk("R12", "B from second strobe", reg_b, 8'h5A);
      slot(2'b01, 8'h01, 8'h02, 8'h80, 8);   // R6 keeps B
      slot(2'b11, 8'h7E, 8'hFF, 8'h55, 8);   // R8
      slot(2'b00, 8'h33, 8'hFF, 8'h66, 5);   // R4 partial
      slot(2'b00, 8'h0F, 8'h01, 8'hF0, 8);   // R5 clears B
      // R9/R10 digital loopback
      slot(2'b01, 8'h11, 8'h40, 8'h99, 8);
      chk("R9", "dloop flag", dloop, 1'b1);
      slot(2'b01, 8'h22, 8'h40, 8'h99, 8);
      slot(2'b01, 8'h3A, 8'h80, 8'h99, 8);
      chk("R9", "aloop flag", aloop, 1'b1);
      chk("R9", "dloop off", dloop, 1'b0);
      slot(2'b01, 8'hC3, 8'hC0, 8'h77, 8);
      chk("R9", "pwrdn flag", pwrdn, 1'b1);
      slot(2'b00, 8'h5C, 8'h00, 8'h77, 8);   // powered down: no output
      // R11 static strap
      static_s = 1'b1; ctl_in = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R11", "static high level", pwrdn, 1'b1);
      ctl_in = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R11", "static low level", pwrdn, 1'b0);
      slot(2'b10, 8'hB4, 8'h00, 8'h4B, 8);   // CA ignored, no write
      static_s = 1'b0;
      // Random slots
      for (int i = 0; i < 80; i++) begin
         logic [1:0] c;
         int nb;
         c  = 2'($urandom_range(3, 0));
         nb = ($urandom_range(7, 0) == 0) ? int'($urandom_range(7, 1)) : 8;
         slot(c, 8'($urandom), 8'($urandom), 8'($urandom), nb);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule